// File: doc/BRIEF.md
# PLL Glitch-Free Retune Sequencer

This block moves a PLL from one frequency to another while keeping the downstream clock clean. A requester presents a rate in MHz. The block looks for an exact match in a small table of divider sets, which is sorted from the highest rate to the lowest. If the clock selector feeding the rest of the chip is currently taking the PLL output, the block first parks the selector on the slow reference. It then drives the PLL through a fixed reconfiguration sequence:

- hold the PLL in reset;
- load the new dividers;
- release reset;
- wait a settling time that scales with the reference divider;
- poll the lock flag against a bounded count.

When the sequence ends, the selector goes back to its original setting.

If lock never appears, the block replays the same sequence once with the divider set that was active before the request. It still reports the timeout. A combinational rounding port answers "which table rate would serve this request" without starting anything. The PLL analog behaviour is outside the block: it only drives the reset and divider pins and reads a lock input.

Top module: `pll_retune_seq`

## Requirements
- R1: A request whose rate matches no table entry ends with `done` and `err_nomatch` high together, one cycle after acceptance. In that case `pll_rst` never rises and every `cfg_*` output keeps its value.
- R2: The selector is parked only when `sel_mode_in` is 1 (normal, PLL output) at acceptance. From the cycle after acceptance until `done`, `clk_sel` then reads 0 (slow). In every other case `clk_sel` equals `sel_mode_in`, and after `done` it follows `sel_mode_in` again.
- R3: For a matched request, `pll_rst` rises 2 cycles after acceptance. The divider outputs then change in successive cycles: first `cfg_nr`/`cfg_od` together, then `cfg_nf`, then `cfg_nb`. `pll_rst` falls the cycle after `cfg_nb` changes. Each divider output carries the table value minus one, and dividers change only while `pll_rst` is high.
- R4: After reset release, lock is ignored for S = ((NR*500)/24+1) * CLK_MHZ cycles, where NR is the table value. If lock is already high, `done` rises S+2 cycles after `pll_rst` falls.
- R5: Lock is sampled once per cycle, at most POLL_MAX times. If no sample sees it, the attempt times out, and `pll_rst` rises again S+POLL_MAX+1 cycles after it fell.
- R6: After a timeout, the block replays the sequence with the divider set that was in force before the request. `done` then arrives with `err_timeout` high, and the `cfg_*` outputs hold the old set.
- R7: The replay never starts a further replay. If it also times out, `done` arrives with `err_timeout` high after exactly two reset pulses.
- R8: `rnd_rate` is the first table rate (highest first) that is not above `rnd_req`. When no entry qualifies, it is the lowest table rate.
- R9: `busy` is high from the cycle after acceptance until `done`. A request made while `busy` is high, or in the cycle `done` is high, is dropped: it causes no second `done` and no reset pulse.
- R10: After reset, the `cfg_*` outputs hold table entry RST_IDX minus one, and `pll_rst`, `busy`, `done`, `err_nomatch` and `err_timeout` are all low.
- R11: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_rate | input | RATE_W | Requested rate in MHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err_nomatch | output | 1 | With done: rate not in table |
| err_timeout | output | 1 | With done: lock timed out, old set restored |
| rnd_req | input | RATE_W | Rate for the rounding query |
| rnd_rate | output | RATE_W | Rounded table rate |
| sel_mode_in | input | 2 | Selector setting chosen by the system (0 slow, 1 PLL, 2 deep slow) |
| clk_sel | output | 2 | Effective selector setting |
| pll_rst | output | 1 | PLL reset |
| cfg_nr | output | NR_W | Reference divider minus one |
| cfg_od | output | OD_W | Output divider minus one |
| cfg_nf | output | NF_W | Feedback divider minus one |
| cfg_nb | output | NB_W | Bandwidth setting minus one |
| pll_lock | input | 1 | PLL lock flag |

## Verification
Each result has a fixed due cycle, counted from the clock edge that accepts a request:

- parking is visible one cycle after acceptance;
- `pll_rst` rises at cycle 2;
- the three divider groups change at cycles 3, 4 and 5;
- `pll_rst` falls at cycle 6;
- `done` follows S+2 cycles later when lock is already high;
- a timeout shows as a second reset rise S+POLL_MAX+1 cycles after the fall.

The bench numbers every negative clock edge after the request and records the index at which each output first changes. It then compares those indices with the figures above, so a result one cycle early or late is caught. The lock model raises lock during the settling window to prove the block does not look at it early.

// File: rtl/pll_retune_pkg.sv
// Shared widths, table entry type, default rate table, selector codes and
// sequencer states for the PLL retune sequencer.
package pll_retune_pkg;

    localparam int RATE_W = 12;
    localparam int NR_W   = 6;
    localparam int OD_W   = 4;
    localparam int NF_W   = 13;
    localparam int NB_W   = 12;
    localparam int US_W   = 12;

    // One table row: rate in MHz and the actual divider values (not minus one)
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [NR_W-1:0]   nr;
        logic [OD_W-1:0]   od;
        logic [NF_W-1:0]   nf;
        logic [NB_W-1:0]   nb;
    } rate_ent_t;

    localparam int DEF_N = 7;

    // Descending order; index 0 is the fastest rate (24 MHz reference)
    localparam rate_ent_t [DEF_N-1:0] DEF_TABLE = '{
        6: '{rate: 12'd48,   nr: 6'd3, od: 4'd4, nf: 13'd24, nb: 12'd12},
        5: '{rate: 12'd126,  nr: 6'd2, od: 4'd2, nf: 13'd21, nb: 12'd11},
        4: '{rate: 12'd408,  nr: 6'd1, od: 4'd2, nf: 13'd34, nb: 12'd17},
        3: '{rate: 12'd600,  nr: 6'd1, od: 4'd2, nf: 13'd50, nb: 12'd25},
        2: '{rate: 12'd768,  nr: 6'd1, od: 4'd1, nf: 13'd32, nb: 12'd16},
        1: '{rate: 12'd1008, nr: 6'd1, od: 4'd1, nf: 13'd42, nb: 12'd21},
        0: '{rate: 12'd1200, nr: 6'd1, od: 4'd1, nf: 13'd50, nb: 12'd25}
    };

    typedef enum logic [1:0] {
        MODE_SLOW = 2'd0,
        MODE_NORM = 2'd1,
        MODE_DEEP = 2'd2
    } sel_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_ON,
        ST_LD_REF,
        ST_LD_FB,
        ST_LD_BW,
        ST_REL,
        ST_SETTLE,
        ST_POLL,
        ST_FIN
    } seq_state_e;

    // Settling time in microseconds for a reference divider value
    function automatic logic [US_W-1:0] settle_us(input logic [NR_W-1:0] nr);
        int t;
        t = (int'(nr) * 500) / 24 + 1;
        return US_W'(t);
    endfunction

endpackage

// File: rtl/rate_lookup.sv
// Rate table lookup: exact match for requests and round-down for queries.
// Assumes TABLE is sorted with the highest rate at index 0.
module rate_lookup
    import pll_retune_pkg::*;
#(
    parameter int N_ENT = DEF_N,
    parameter rate_ent_t [N_ENT-1:0] TABLE = DEF_TABLE
) (
    input  logic [RATE_W-1:0] req_rate,
    output logic              hit,
    output rate_ent_t         hit_ent,
    input  logic [RATE_W-1:0] rnd_req,
    output logic [RATE_W-1:0] rnd_rate
);

    logic [N_ENT-1:0] eq_flag;
    logic [N_ENT-1:0] ge_flag;

    // Per-entry comparators
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign eq_flag[i] = (req_rate == TABLE[i].rate);
        assign ge_flag[i] = (rnd_req >= TABLE[i].rate);
    end

    // Priority pick: the lowest index that qualifies wins
    always_comb begin
        hit      = 1'b0;
        hit_ent  = TABLE[0];
        rnd_rate = TABLE[N_ENT-1].rate;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (eq_flag[i]) begin
                hit     = 1'b1;
                hit_ent = TABLE[i];
            end
            if (ge_flag[i]) begin
                rnd_rate = TABLE[i].rate;
            end
        end
    end

endmodule

// File: rtl/usec_ticker.sv
// Microsecond prescaler: pulses tick once every CLK_MHZ cycles while clr is
// low; clr holds the count at zero. Assumes CLK_MHZ >= 1.
module usec_ticker #(
    parameter int CLK_MHZ = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    if (CLK_MHZ == 1) begin : g_unit
        assign tick = !clr;
    end else begin : g_div
        localparam int PW = $clog2(CLK_MHZ);
        logic [PW-1:0] pre;

        assign tick = (pre == PW'(CLK_MHZ - 1));

        // Count cycles within one microsecond
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                pre <= '0;
            end else if (tick) begin
                pre <= '0;
            end else begin
                pre <= pre + PW'(1);
            end
        end
    end

endmodule

// File: rtl/pll_retune_seq.sv
// PLL retune sequencer top. Accepts a rate request, parks the clock selector
// off the PLL if needed, reprograms the dividers under reset, waits the
// settling time, polls lock with a bound, and replays the previous settings
// once on timeout. Assumes pll_lock is synchronous to clk and that table
// divider values fit their fields and are at least 1.
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int N_ENT = DEF_N,
    parameter rate_ent_t [N_ENT-1:0] TABLE = DEF_TABLE,
    parameter int RST_IDX  = 4,
    parameter int CLK_MHZ  = 200,
    parameter int POLL_MAX = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RATE_W-1:0] req_rate,
    output logic              busy,
    output logic              done,
    output logic              err_nomatch,
    output logic              err_timeout,
    input  logic [RATE_W-1:0] rnd_req,
    output logic [RATE_W-1:0] rnd_rate,
    input  logic [1:0]        sel_mode_in,
    output logic [1:0]        clk_sel,
    output logic              pll_rst,
    output logic [NR_W-1:0]   cfg_nr,
    output logic [OD_W-1:0]   cfg_od,
    output logic [NF_W-1:0]   cfg_nf,
    output logic [NB_W-1:0]   cfg_nb,
    input  logic              pll_lock
);

    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam rate_ent_t BOOT = TABLE[RST_IDX];

    seq_state_e         state;
    rate_ent_t          tgt;
    rate_ent_t          prev;
    logic               parked;
    logic               fallback;
    logic               to_flag;
    logic [US_W-1:0]    settle_cnt;
    logic [POLL_W-1:0]  poll_cnt;
    logic               hit;
    rate_ent_t          hit_ent;
    logic               tick;
    logic               accept;
    logic               tick_clr;

    rate_lookup #(
        .N_ENT (N_ENT),
        .TABLE (TABLE)
    ) u_lookup (
        .req_rate (req_rate),
        .hit      (hit),
        .hit_ent  (hit_ent),
        .rnd_req  (rnd_req),
        .rnd_rate (rnd_rate)
    );

    assign tick_clr = (state != ST_SETTLE);

    usec_ticker #(
        .CLK_MHZ (CLK_MHZ)
    ) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    // Request accepted only when idle and not in the done cycle
    assign accept  = req_valid && (state == ST_IDLE) && !done;
    assign busy    = (state != ST_IDLE);
    // Parked selector forces the slow source
    assign clk_sel = parked ? MODE_SLOW : sel_mode_in;

    // Sequencer state, PLL pins and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tgt         <= BOOT;
            prev        <= BOOT;
            parked      <= 1'b0;
            fallback    <= 1'b0;
            to_flag     <= 1'b0;
            settle_cnt  <= '0;
            poll_cnt    <= '0;
            done        <= 1'b0;
            err_nomatch <= 1'b0;
            err_timeout <= 1'b0;
            pll_rst     <= 1'b0;
            cfg_nr      <= BOOT.nr - NR_W'(1);
            cfg_od      <= BOOT.od - OD_W'(1);
            cfg_nf      <= BOOT.nf - NF_W'(1);
            cfg_nb      <= BOOT.nb - NB_W'(1);
        end else begin
            done        <= 1'b0;
            err_nomatch <= 1'b0;
            err_timeout <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            tgt      <= hit_ent;
                            fallback <= 1'b0;
                            to_flag  <= 1'b0;
                            parked   <= (sel_mode_in == MODE_NORM);
                            state    <= ST_RST_ON;
                        end else begin
                            done        <= 1'b1;
                            err_nomatch <= 1'b1;
                        end
                    end
                end
                ST_RST_ON: begin
                    pll_rst <= 1'b1;
                    state   <= ST_LD_REF;
                end
                ST_LD_REF: begin
                    cfg_nr <= tgt.nr - NR_W'(1);
                    cfg_od <= tgt.od - OD_W'(1);
                    state  <= ST_LD_FB;
                end
                ST_LD_FB: begin
                    cfg_nf <= tgt.nf - NF_W'(1);
                    state  <= ST_LD_BW;
                end
                ST_LD_BW: begin
                    cfg_nb <= tgt.nb - NB_W'(1);
                    state  <= ST_REL;
                end
                ST_REL: begin
                    pll_rst    <= 1'b0;
                    settle_cnt <= settle_us(tgt.nr);
                    state      <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (tick) begin
                        if (settle_cnt == US_W'(1)) begin
                            poll_cnt <= '0;
                            state    <= ST_POLL;
                        end else begin
                            settle_cnt <= settle_cnt - US_W'(1);
                        end
                    end
                end
                ST_POLL: begin
                    if (pll_lock) begin
                        state <= ST_FIN;
                    end else if (poll_cnt == POLL_W'(POLL_MAX - 1)) begin
                        to_flag <= 1'b1;
                        if (!fallback) begin
                            fallback <= 1'b1;
                            tgt      <= prev;
                            state    <= ST_RST_ON;
                        end else begin
                            state <= ST_FIN;
                        end
                    end else begin
                        poll_cnt <= poll_cnt + POLL_W'(1);
                    end
                end
                ST_FIN: begin
                    done        <= 1'b1;
                    err_timeout <= to_flag;
                    parked      <= 1'b0;
                    prev        <= tgt;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pll_retune_chk.sv
// Protocol checker for pll_retune_seq, attached by bind. Observes ports only.
module pll_retune_chk
    import pll_retune_pkg::*;
#(
    parameter int NRW = NR_W,
    parameter int ODW = OD_W,
    parameter int NFW = NF_W,
    parameter int NBW = NB_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           err_nomatch,
    input logic           err_timeout,
    input logic           pll_rst,
    input logic [1:0]     clk_sel,
    input logic           pll_lock,
    input logic [NRW-1:0] cfg_nr,
    input logic [ODW-1:0] cfg_od,
    input logic [NFW-1:0] cfg_nf,
    input logic [NBW-1:0] cfg_nb
);

    // Dividers move only while the PLL is already held in reset
    assert_cfg_under_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_nr, cfg_od, cfg_nf, cfg_nb}) |-> (pll_rst && $past(pll_rst)));

    // Selector never shows the PLL while it is in reset
    assert_parked_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> (clk_sel != MODE_NORM));

    // Completion is a single-cycle pulse
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A table miss touches nothing
    assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err_nomatch |-> (done && !pll_rst && !err_timeout && !busy));

    // Clean completion only after a lock sample
    assert_lock_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_nomatch && !err_timeout) |-> $past(pll_lock, 2));

    // Busy drops only together with done
    assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

endmodule

bind pll_retune_seq pll_retune_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .err_nomatch (err_nomatch),
    .err_timeout (err_timeout),
    .pll_rst     (pll_rst),
    .clk_sel     (clk_sel),
    .pll_lock    (pll_lock),
    .cfg_nr      (cfg_nr),
    .cfg_od      (cfg_od),
    .cfg_nf      (cfg_nf),
    .cfg_nb      (cfg_nb)
);

// File: tb/test_pll_retune_seq.sv
// Self-checking bench: vector table walk followed by directed tests.
module test_pll_retune_seq;
    import pll_retune_pkg::*;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CMHZ  = 4;
    localparam int PMAX  = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [RATE_W-1:0] req_rate = '0;
    logic              busy, done, err_nomatch, err_timeout;
    logic [RATE_W-1:0] rnd_req = '0;
    logic [RATE_W-1:0] rnd_rate;
    logic [1:0]        sel_mode_in = 2'd1;
    logic [1:0]        clk_sel;
    logic              pll_rst;
    logic [NR_W-1:0]   cfg_nr;
    logic [OD_W-1:0]   cfg_od;
    logic [NF_W-1:0]   cfg_nf;
    logic [NB_W-1:0]   cfg_nb;
    logic              pll_lock;

    int lock_pol = 1;
    int rises    = 0;
    int n_chk    = 0;
    int n_fail   = 0;
    int wd       = 0;

    // Lock model: 0 never, 1 whenever out of reset, 2 only on the second attempt
    assign pll_lock = !pll_rst && (lock_pol == 1 || (lock_pol == 2 && rises >= 2));

    always #2.5 clk = ~clk;

    pll_retune_seq #(
        .CLK_MHZ  (CMHZ),
        .POLL_MAX (PMAX)
    ) i_pll_retune_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rate(req_rate),
        .busy(busy), .done(done), .err_nomatch(err_nomatch), .err_timeout(err_timeout),
        .rnd_req(rnd_req), .rnd_rate(rnd_rate), .sel_mode_in(sel_mode_in),
        .clk_sel(clk_sel), .pll_rst(pll_rst), .cfg_nr(cfg_nr), .cfg_od(cfg_od),
        .cfg_nf(cfg_nf), .cfg_nb(cfg_nb), .pll_lock(pll_lock)
    );

    // Watchdog
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act %0d cycles exp below 150000", wd);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    function automatic int settle_cycles(input int nr);
        return ((nr * 500) / 24 + 1) * CMHZ;
    endfunction

    task automatic check_cfg(input string req, input int nr, input int od, input int nf, input int nb);
        check(int'(cfg_nr) == nr - 1, req, int'(cfg_nr), nr - 1);
        check(int'(cfg_od) == od - 1, req, int'(cfg_od), od - 1);
        check(int'(cfg_nf) == nf - 1, req, int'(cfg_nf), nf - 1);
        check(int'(cfg_nb) == nb - 1, req, int'(cfg_nb), nb - 1);
    endtask

    // Observed event indices, negedges counted from the request edge
    int t_rise1, t_rise2, t_nrod, t_nf, t_nb, t_fall1, t_done;
    bit sel_bad, got_nm, got_to;

    task automatic run_req(input int rate, input int sel, input int pol, input int inj_rate);
        logic [NR_W+OD_W-1:0] p_ro;
        logic [NF_W-1:0] p_nf;
        logic [NB_W-1:0] p_nb;
        logic p_rst;
        t_rise1 = -1; t_rise2 = -1; t_nrod = -1; t_nf = -1; t_nb = -1;
        t_fall1 = -1; t_done = -1; sel_bad = 0; got_nm = 0; got_to = 0;
        rises = 0;
        @(negedge clk);
        sel_mode_in = 2'(sel);
        lock_pol    = pol;
        req_valid   = 1'b1;
        req_rate    = RATE_W'(rate);
        p_ro = {cfg_nr, cfg_od}; p_nf = cfg_nf; p_nb = cfg_nb; p_rst = pll_rst;
        for (int c = 1; c < 20000; c++) begin
            @(negedge clk);
            if (c == 1) req_valid = 1'b0;
            if (inj_rate > 0 && c == 10) begin req_valid = 1'b1; req_rate = RATE_W'(inj_rate); end
            if (c == 11) req_valid = 1'b0;
            if (pll_rst && !p_rst) begin
                rises = rises + 1;
                if (rises == 1) t_rise1 = c;
                if (rises == 2) t_rise2 = c;
            end
            if (!pll_rst && p_rst && t_fall1 < 0) t_fall1 = c;
            if (rises == 1 && {cfg_nr, cfg_od} != p_ro && t_nrod < 0) t_nrod = c;
            if (rises == 1 && cfg_nf != p_nf && t_nf < 0) t_nf = c;
            if (rises == 1 && cfg_nb != p_nb && t_nb < 0) t_nb = c;
            if (busy && sel == 1 && clk_sel != 2'd0) sel_bad = 1;
            if (busy && sel != 1 && int'(clk_sel) != sel) sel_bad = 1;
            p_ro = {cfg_nr, cfg_od}; p_nf = cfg_nf; p_nb = cfg_nb; p_rst = pll_rst;
            if (done) begin
                t_done = c; got_nm = err_nomatch; got_to = err_timeout;
                break;
            end
        end
        @(negedge clk);
        check(!done, "R11 done single cycle", int'(done), 0);
        check(int'(clk_sel) == sel, "R2 selector restored", int'(clk_sel), sel);
    endtask

    // Vector table: rate, selector, hit, expected dividers after the request
    localparam int NV = 5;
    localparam int V_RATE[NV] = '{1200, 48, 126, 500, 768};
    localparam int V_SEL [NV] = '{1, 0, 2, 1, 1};
    localparam int V_HIT [NV] = '{1, 1, 1, 0, 1};
    localparam int V_NR  [NV] = '{1, 3, 2, 2, 1};
    localparam int V_OD  [NV] = '{1, 4, 2, 2, 1};
    localparam int V_NF  [NV] = '{50, 24, 21, 21, 32};
    localparam int V_NB  [NV] = '{25, 12, 11, 11, 16};

    initial begin
        // R10 reset state
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_cfg("R10 reset dividers", 1, 2, 34, 17);
        check(!pll_rst && !busy && !done && !err_nomatch && !err_timeout,
              "R10 reset flags", {pll_rst, busy, done, err_nomatch, err_timeout}, 0);
        check(clk_sel == 2'd1, "R2 idle selector follows", int'(clk_sel), 1);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            run_req(V_RATE[v], V_SEL[v], 1, 0);
            check_cfg(V_HIT[v] != 0 ? "R3 dividers loaded" : "R1 dividers kept",
                      V_NR[v], V_OD[v], V_NF[v], V_NB[v]);
            check(!sel_bad, "R2 parking", int'(sel_bad), 0);
            check(!got_to, "R6 no timeout flag", int'(got_to), 0);
            if (V_HIT[v] != 0) begin
                check(t_rise1 == 2, "R3 reset rises", t_rise1, 2);
                if (t_nrod >= 0) check(t_nrod == 3, "R3 ref/out dividers step", t_nrod, 3);
                check(t_nf == 4, "R3 feedback step", t_nf, 4);
                check(t_nb == 5, "R3 bandwidth step", t_nb, 5);
                check(t_fall1 == 6, "R3 reset falls", t_fall1, 6);
                check(t_done - t_fall1 == settle_cycles(V_NR[v]) + 2, "R4 settle delay",
                      t_done - t_fall1, settle_cycles(V_NR[v]) + 2);
                check(!got_nm, "R1 hit not flagged", int'(got_nm), 0);
            end else begin
                check(got_nm && t_done == 1, "R1 miss flagged", t_done, 1);
                check(rises == 0, "R1 no reset pulse", rises, 0);
            end
        end

        // R8 rounding
        begin
            int q[5] = '{2000, 1200, 700, 10, 407};
            int e[5] = '{1200, 1200, 600, 48, 126};
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                rnd_req = RATE_W'(q[k]);
                #1;
                check(int'(rnd_rate) == e[k], "R8 rounding", int'(rnd_rate), e[k]);
            end
        end

        // R9 request while busy is dropped
        run_req(600, 1, 1, 1200);
        check_cfg("R9 busy request dropped", 1, 2, 50, 25);
        check(rises == 1, "R9 single reset pulse", rises, 1);
        begin
            bit extra = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (done || pll_rst) extra = 1;
            end
            check(!extra, "R9 no late activity", int'(extra), 0);
        end

        // R5, R6 timeout then fallback locks
        run_req(1008, 1, 2, 0);
        check(t_rise2 - t_fall1 == settle_cycles(1) + PMAX + 1, "R5 poll bound",
              t_rise2 - t_fall1, settle_cycles(1) + PMAX + 1);
        check(got_to && !got_nm, "R6 timeout reported", int'(got_to), 1);
        check_cfg("R6 old dividers restored", 1, 2, 50, 25);
        check(!sel_bad, "R2 parked during replay", int'(sel_bad), 0);

        // R7 replay also fails: no further attempt
        run_req(48, 2, 0, 0);
        check(rises == 2, "R7 exactly two attempts", rises, 2);
        check(got_to && t_done > 0, "R7 timeout reported", int'(got_to), 1);
        check_cfg("R7 old dividers kept", 1, 2, 50, 25);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule